// File: doc/BRIEF.md
# LCD Row Scan and Segment Shift Sequencer

This block produces the timing for a multiplexed character dot-matrix panel. It divides its clock into half-periods of a slow serial clock. Each display row becomes one burst of segment shifts followed by a single latch pulse. The block drives the common lines one-hot, one row at a time, and the segment lines from a latch. It also brings the serial data, the shift clock, the latch clock and the polarity-alternation flag out to pins, so that external segment-driver chips can sit on the same chain and extend the panel.

The row count comes from two configuration bits. Two-line operation scans 16 commons. One line with the tall font scans 11. One line with the short font scans 8. The controller core watches `row_sel` and presents that row's pixel bits on `pix_row_data`. The block captures the word at the start of the row's shift burst. It then sends the bits out serially, lowest index first, while the row before it is still being shown. At the row boundary the latch pulse transfers the shifted word to the segment outputs and moves the active common on to the next row. The polarity flag flips on every latch that activates common 0, so it toggles once per frame.

Top module: `lcd_scan_gen`

## Requirements
- R1: Scan length follows the mode inputs. `two_line`=1 gives 16 rows. `two_line`=0 with `tall_font`=1 gives 11 rows. Both inputs at 0 gives 8 rows. Rows run 0,1,…,last and then wrap to 0.
- R2: While `rst_n` is low, `com_out`, `seg_out`, `ser_data`, `shift_clk`, `latch_clk`, `ac_phase` and `row_sel` are all 0.
- R3: At each latch pulse, `com_out` becomes the one-hot code of the row just shifted: bit i of `com_out` is high for row i. At most one common is high at any time, and `com_out` changes only on a rising `latch_clk`.
- R4: Each row has exactly NUM_SEG `shift_clk` pulses. Each pulse is high for HALF_DIV clocks and low for at least HALF_DIV clocks.
- R5: The k-th shift pulse of a row carries bit k of the `pix_row_data` word that was presented while `row_sel` named that row. `ser_data` changes only while `shift_clk` is low.
- R6: `latch_clk` pulses once per row, after the last shift of the row, and is high for HALF_DIV clocks. Successive latch pulses are (2·NUM_SEG+2)·HALF_DIV clocks apart.
- R7: On a rising `latch_clk`, `seg_out[i]` takes bit i of the row just shifted. It holds that value until the next latch pulse.
- R8: `ac_phase` inverts on the latch pulse that activates common 0, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_line | input | 1 | Two-line mode (16 rows) |
| tall_font | input | 1 | Tall font in one-line mode (11 rows) |
| pix_row_data | input | NUM_SEG | Pixel bits for the row named by `row_sel` |
| row_sel | output | $clog2(NUM_COM) | Row whose pixel bits are being fetched and shifted |
| com_out | output | NUM_COM | One-hot common drive |
| seg_out | output | NUM_SEG | Latched segment drive |
| ser_data | output | 1 | Serial pixel bit for cascaded drivers |
| shift_clk | output | 1 | Serial shift clock |
| latch_clk | output | 1 | Row latch clock |
| ac_phase | output | 1 | Frame polarity alternation flag |

## Verification
The bench builds the block with NUM_SEG=6 and HALF_DIV=2, which gives a 28-clock row. At that size every scan mode can be run through more than two complete frames in a few thousand cycles, so every row of every duty is latched, checked and wrapped at least twice. Each mode is run after its own reset and with a different pixel pattern. Every shift edge, every latch edge and every change of polarity is compared against values the bench works out arithmetically.

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen #(
  parameter int unsigned NUM_COM  = 16,
  parameter int unsigned NUM_SEG  = 40,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       two_line,
  input  logic                       tall_font,
  input  logic [NUM_SEG-1:0]         pix_row_data,
  output logic [$clog2(NUM_COM)-1:0] row_sel,
  output logic [NUM_COM-1:0]         com_out,
  output logic [NUM_SEG-1:0]         seg_out,
  output logic                       ser_data,
  output logic                       shift_clk,
  output logic                       latch_clk,
  output logic                       ac_phase
);
  localparam int unsigned ROW_W     = $clog2(NUM_COM);
  localparam int unsigned STEP_LAST = 2 * NUM_SEG + 1;
  localparam int unsigned STEP_W    = $clog2(STEP_LAST + 1);
  localparam int unsigned SIDX_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam int unsigned DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0]   div_cnt;
  logic [STEP_W-1:0]  step, step_nxt;
  logic [NUM_SEG-1:0] tx_buf, seg_sr;
  logic [ROW_W:0]     rows;
  logic               tick, nxt_shift, nxt_latch, nxt_load, nxt_bit, row_wrap;
  logic [SIDX_W-1:0]  bit_idx;

  assign rows = two_line  ? (ROW_W+1)'(16) :
                tall_font ? (ROW_W+1)'(11) : (ROW_W+1)'(8);

  assign tick      = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign step_nxt  = (step == STEP_W'(STEP_LAST)) ? '0 : step + 1'b1;
  assign nxt_shift = step_nxt[0] && (step_nxt < STEP_W'(2 * NUM_SEG));
  assign nxt_latch = (step_nxt == STEP_W'(2 * NUM_SEG));
  assign nxt_load  = (step_nxt == '0);
  assign nxt_bit   = !step_nxt[0] && (step_nxt < STEP_W'(2 * NUM_SEG));
  assign bit_idx   = SIDX_W'(step_nxt >> 1);
  assign row_wrap  = ({1'b0, row_sel} >= rows - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      step      <= STEP_W'(STEP_LAST);
      tx_buf    <= '0;
      seg_sr    <= '0;
      seg_out   <= '0;
      com_out   <= '0;
      row_sel   <= '0;
      ser_data  <= 1'b0;
      shift_clk <= 1'b0;
      latch_clk <= 1'b0;
      ac_phase  <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        step      <= step_nxt;
        shift_clk <= nxt_shift;
        latch_clk <= nxt_latch;
        if (nxt_load) begin
          tx_buf   <= pix_row_data;
          ser_data <= pix_row_data[0];
        end else if (nxt_bit) begin
          ser_data <= tx_buf[bit_idx];
        end
        if (nxt_shift)
          seg_sr <= {ser_data, seg_sr[NUM_SEG-1:1]};
        if (nxt_latch) begin
          seg_out <= seg_sr;
          com_out <= NUM_COM'(1) << row_sel;
          if (row_sel == '0) ac_phase <= ~ac_phase;
          row_sel <= row_wrap ? '0 : row_sel + 1'b1;
        end
      end
    end
  end

  // R3
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_out));

  // R3
  com_moves_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(com_out) |-> $rose(latch_clk));

  // R5
  ser_quiet_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> !shift_clk);

  // R6
  clocks_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_clk && latch_clk));

  // R7
  seg_moves_on_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_out) |-> $rose(latch_clk));

  // R8
  ac_flip_on_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac_phase) |-> ($rose(latch_clk) && com_out[0]));
endmodule

// File: tb/lcd_scan_gen_test.sv
module lcd_scan_gen_test;
  localparam int unsigned NC = 16;
  localparam int unsigned NS = 6;
  localparam int unsigned HD = 2;
  localparam int unsigned ROW_CLKS = (2 * NS + 2) * HD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_line = 1'b0, tall_font = 1'b0;
  logic [NS-1:0] pix;
  logic [$clog2(NC)-1:0] row_sel;
  logic [NC-1:0] com_out;
  logic [NS-1:0] seg_out;
  logic ser_data, shift_clk, latch_clk, ac_phase;

  int checks = 0, fails = 0;
  int seed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [NS-1:0] pat(input int row, input int sd);
    return NS'(row * 37 + sd * 11);
  endfunction

  assign pix = pat(int'(row_sel), seed);

  lcd_scan_gen #(.NUM_COM(NC), .NUM_SEG(NS), .HALF_DIV(HD)) uut (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
    .pix_row_data(pix), .row_sel(row_sel), .com_out(com_out),
    .seg_out(seg_out), .ser_data(ser_data), .shift_clk(shift_clk),
    .latch_clk(latch_clk), .ac_phase(ac_phase));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  int exp_row, sh_cnt, hi_cnt, lo_cnt, lhi_cnt, row_clk, n_latch, duty;
  bit seen_latch;
  logic [NS-1:0] cap, p_seg;
  logic [NC-1:0] p_com;
  logic p_ser, p_sclk, p_lclk, p_ac;

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_row = 0; sh_cnt = 0; hi_cnt = 0; lo_cnt = HD; lhi_cnt = 0;
      row_clk = 0; n_latch = 0; seen_latch = 1'b0; cap = '0;
    end else begin
      row_clk++;
      if (shift_clk && !p_sclk) begin
        // R4 low width, R5 data held across rising edge
        chk(lo_cnt >= HD, "R4 shift low width", lo_cnt, HD);
        chk(ser_data == p_ser, "R5 data stable at shift", ser_data, p_ser);
        if (sh_cnt < NS) cap[sh_cnt] = ser_data;
        sh_cnt++;
        hi_cnt = 1;
      end else if (shift_clk) hi_cnt++;
      if (!shift_clk && p_sclk) begin
        chk(hi_cnt == HD, "R4 shift high width", hi_cnt, HD);
        lo_cnt = 1;
      end else if (!shift_clk) lo_cnt++;
      if (ser_data != p_ser)
        chk(!shift_clk, "R5 data moves with clock low", shift_clk, 0);
      if (latch_clk && !p_lclk) begin
        chk(sh_cnt == NS, "R4 shifts per row", sh_cnt, NS);
        chk(cap == pat(exp_row, seed), "R5 serial bits", cap, pat(exp_row, seed));
        chk(seg_out == pat(exp_row, seed), "R7 segment latch", seg_out, pat(exp_row, seed));
        chk(com_out == NC'(1) << exp_row, "R1/R3 active common", com_out, NC'(1) << exp_row);
        chk((ac_phase != p_ac) == (exp_row == 0), "R8 polarity flip", ac_phase, p_ac ^ (exp_row == 0));
        if (seen_latch) chk(row_clk == ROW_CLKS, "R6 row period", row_clk, ROW_CLKS);
        seen_latch = 1'b1;
        row_clk = 0; sh_cnt = 0; lhi_cnt = 1; n_latch++;
        exp_row = (exp_row + 1 == duty) ? 0 : exp_row + 1;
      end else begin
        if (latch_clk) lhi_cnt++;
        if (!latch_clk && p_lclk) chk(lhi_cnt == HD, "R6 latch width", lhi_cnt, HD);
        chk(seg_out == p_seg && com_out == p_com, "R7 hold between latches", seg_out, p_seg);
        chk(ac_phase == p_ac, "R8 polarity steady", ac_phase, p_ac);
      end
    end
    p_ser = ser_data; p_sclk = shift_clk; p_lclk = latch_clk;
    p_ac = ac_phase; p_seg = seg_out; p_com = com_out;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      rst_n = 1'b0;
      two_line = m[1]; tall_font = m[0];
      seed = m + 1;
      // R1 duty per mode
      duty = two_line ? 16 : (tall_font ? 11 : 8);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2 reset state
      chk({com_out, seg_out, ser_data, shift_clk, latch_clk, ac_phase} == '0,
          "R2 reset outputs", {com_out, seg_out}, 0);
      chk(row_sel == '0, "R2 reset row", row_sel, 0);
      rst_n = 1'b1;
      while (n_latch < 2 * duty + 3) @(negedge clk);
      chk(n_latch >= 2 * duty + 3, "R1 frames scanned", n_latch, 2 * duty + 3);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule